// File: doc/BRIEF.md
# DMA Channel Status and Condition Unit

This block keeps the 16-bit control and status word of one descriptor-driven DMA channel. The upper byte holds the channel's run state: running, paused, flushing, woken, dead and active. Bit 8 records whether the most recently completed command branched. The low byte is a device-dependent status field. Both the host and the attached device change that field with masked writes: a mask picks the bits, and each picked bit takes the matching value bit.

Three selectors are programmed by the host, one each for interrupt, branch and wait. Each selector holds an 8-bit mask and an 8-bit value. Its condition holds when the device byte ANDed with the mask equals the value. For the command in progress, the descriptor engine presents a 2-bit flag per condition. The unit turns each flag and its condition into an interrupt request, a branch decision or a stall.

When the engine signals that a command is finished and nothing holds it back, the unit accepts the completion. In that same cycle it presents a writeback word: the channel status, followed by the residual byte count, which is the requested count minus the transferred count.

Top module: `dmastat_unit`

## Requirements
- R1: After a synchronous reset the status word is zero and every selector holds mask 0 and value 0, so each condition reads true.
- R2: Status bits are laid out as RUN 15, PAUSE 14, FLUSH 13, WAKE 12, DEAD 11, ACTIVE 10, always-zero 9, BRANCH 8 and device byte 7..0. A host control write changes RUN, PAUSE and FLUSH under mask and value bits 3, 2 and 1, leaving unselected bits unchanged.
- R3: A host write that selects RUN sets ACTIVE to the written RUN value and clears DEAD; ACTIVE and DEAD are never both set.
- R4: dead_event sets DEAD and clears ACTIVE on the next cycle, overriding a same-cycle RUN write for those two bits.
- R5: A host write with mask bit 0 and value bit 0 set raises WAKE, and WAKE clears one cycle later unless it is written again.
- R6: flush_done clears FLUSH, except that a host write selecting FLUSH in the same cycle takes precedence.
- R7: The host and the device each update the device byte as (old & ~mask) | (value & mask); where both select a bit in one cycle, the device value wins.
- R8: A selector write with sel_idx 0, 1 or 2 loads the interrupt, branch or wait selector respectively; sel_idx 3 changes nothing. A condition is true when (device byte & mask) == value.
- R9: The flag encoding is 0 never, 1 when the condition is true, 2 when it is false, 3 always. interrupt_req, branch_take and wait_stall follow it while cmd_valid is high and are low otherwise.
- R10: cmp_valid is high exactly when cmd_valid, cmd_done and ACTIVE are high while PAUSE and wait_stall are low.
- R11: While cmp_valid is high, cmp_word carries the status word with bit 8 replaced by branch_take in its upper 16 bits and (requested − transferred) modulo 2^16 in its lower 16 bits. The same completion loads BRANCH with branch_take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ctl_we | input | 1 | Host control write strobe |
| host_ctl_mask | input | 4 | Control mask: bit 3 RUN, 2 PAUSE, 1 FLUSH, 0 WAKE |
| host_ctl_val | input | 4 | Control values, same bit order |
| host_dev_we | input | 1 | Host device-byte write strobe |
| host_dev_mask | input | 8 | Host device-byte mask |
| host_dev_val | input | 8 | Host device-byte values |
| sel_we | input | 1 | Selector write strobe |
| sel_idx | input | 2 | Selector: 0 interrupt, 1 branch, 2 wait, 3 none |
| sel_mask | input | 8 | Selector mask to load |
| sel_val | input | 8 | Selector value to load |
| dev_upd_we | input | 1 | Device status update strobe |
| dev_upd_mask | input | 8 | Device update mask |
| dev_upd_val | input | 8 | Device update values |
| dead_event | input | 1 | Fatal channel error |
| flush_done | input | 1 | Buffered data written out |
| cmd_valid | input | 1 | A command is in progress |
| cmd_int_flag | input | 2 | Interrupt flag of the command |
| cmd_br_flag | input | 2 | Branch flag of the command |
| cmd_wait_flag | input | 2 | Wait flag of the command |
| cmd_done | input | 1 | Command transfer finished, requests completion |
| cmd_req_count | input | 16 | Requested byte count |
| cmd_xfer_count | input | 16 | Transferred byte count |
| status | output | 16 | Channel status word |
| interrupt_req | output | 1 | Raise interrupt for this command |
| branch_take | output | 1 | Take branch for this command |
| wait_stall | output | 1 | Command stalled by wait condition |
| cmp_valid | output | 1 | Completion accepted this cycle |
| cmp_word | output | 32 | Writeback: status over residual |

## Verification
Every flag encoding is paired with a true and a false condition for each of the three selectors. A value of 0xA5 matches the programmed selector and 0x55 misses it, which separates the if-true and if-false encodings from never and always. Overlapping host and device masks, the 0x03/0 clearing case and a write to selector index 3 show how the masked update and the selector bank resolve collisions. A completion is attempted while paused, while stalled and after a dead event, and then with a transferred count larger than the requested count. This shows the gating and the residual wraparound, and whether the branch outcome reaches both the writeback and bit 8.

// File: rtl/dmastat_pkg.sv
package dmastat_pkg;

    localparam int DEV_W    = 8;
    localparam int STAT_W   = 16;
    localparam int NUM_COND = 3;

    // host control field positions
    localparam int CTL_RUN   = 3;
    localparam int CTL_PAUSE = 2;
    localparam int CTL_FLUSH = 1;
    localparam int CTL_WAKE  = 0;

    // condition slots, shared by selector index and request vector
    localparam int C_INT  = 0;
    localparam int C_BR   = 1;
    localparam int C_WAIT = 2;

    typedef enum logic [1:0] {
        FLG_NEVER    = 2'd0,
        FLG_IF_TRUE  = 2'd1,
        FLG_IF_FALSE = 2'd2,
        FLG_ALWAYS   = 2'd3
    } cond_flag_e;

    typedef struct packed {
        logic [DEV_W-1:0] mask;
        logic [DEV_W-1:0] value;
    } selector_t;

    typedef struct packed {
        logic run;
        logic pause;
        logic flush;
        logic wake;
        logic dead;
        logic active;
    } run_state_t;

    function automatic logic sel_match(input logic [DEV_W-1:0] dev, input selector_t s);
        return (dev & s.mask) == s.value;
    endfunction

    function automatic logic flag_apply(input cond_flag_e f, input logic c);
        case (f)
            FLG_NEVER:    return 1'b0;
            FLG_IF_TRUE:  return c;
            FLG_IF_FALSE: return !c;
            default:      return 1'b1;
        endcase
    endfunction

    function automatic logic [DEV_W-1:0] merge_masked(input logic [DEV_W-1:0] old,
                                                      input logic [DEV_W-1:0] m,
                                                      input logic [DEV_W-1:0] v);
        return (old & ~m) | (v & m);
    endfunction

endpackage

// File: rtl/dmastat_cond.sv
module dmastat_cond
    import dmastat_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           sel_we,
    input  logic [1:0]                     sel_idx,
    input  logic [DEV_W-1:0]               sel_mask,
    input  logic [DEV_W-1:0]               sel_val,
    input  logic [DEV_W-1:0]               dev_status,
    input  logic                           cmd_valid,
    input  logic [NUM_COND-1:0][1:0]       flags,
    output logic [NUM_COND-1:0]            req
);

    for (genvar g = 0; g < NUM_COND; g++) begin : g_slot
        selector_t sel_q;
        logic      hit;

        always_ff @(posedge clk) begin
            if (rst)
                sel_q <= '0;
            else if (sel_we && sel_idx == 2'(g))
                sel_q <= '{mask: sel_mask, value: sel_val};
        end

        assign hit    = sel_match(dev_status, sel_q);
        assign req[g] = cmd_valid && flag_apply(cond_flag_e'(flags[g]), hit);
    end

    // R9: no request is raised without a command in progress
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> req == '0);

    // R9: a never-flag keeps its output low, an always-flag drives it high
    a_r9_never_always: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && flags[C_INT] == 2'd3 && flags[C_WAIT] == 2'd0 |-> req[C_INT] && !req[C_WAIT]);

endmodule

// File: rtl/dmastat_ctrl.sv
module dmastat_ctrl
    import dmastat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [3:0]       ctl_mask,
    input  logic [3:0]       ctl_val,
    input  logic             hdev_we,
    input  logic [DEV_W-1:0] hdev_mask,
    input  logic [DEV_W-1:0] hdev_val,
    input  logic             ddev_we,
    input  logic [DEV_W-1:0] ddev_mask,
    input  logic [DEV_W-1:0] ddev_val,
    input  logic             dead_event,
    input  logic             flush_done,
    input  logic             complete,
    input  logic             branch_taken,
    output run_state_t       state,
    output logic [DEV_W-1:0] dev_status,
    output logic             brk
);

    run_state_t       st_n;
    logic [DEV_W-1:0] dev_n;
    logic             brk_n;
    logic             run_wr;
    logic             wake_wr;
    logic             flush_wr;

    assign run_wr   = ctl_we && ctl_mask[CTL_RUN];
    assign flush_wr = ctl_we && ctl_mask[CTL_FLUSH];
    assign wake_wr  = ctl_we && ctl_mask[CTL_WAKE] && ctl_val[CTL_WAKE];

    always_comb begin
        st_n = state;
        if (run_wr)
            st_n.run = ctl_val[CTL_RUN];
        if (ctl_we && ctl_mask[CTL_PAUSE])
            st_n.pause = ctl_val[CTL_PAUSE];
        if (flush_wr)
            st_n.flush = ctl_val[CTL_FLUSH];
        else if (flush_done)
            st_n.flush = 1'b0;
        st_n.wake = wake_wr;
        if (dead_event) begin
            st_n.dead   = 1'b1;
            st_n.active = 1'b0;
        end else if (run_wr) begin
            st_n.dead   = 1'b0;
            st_n.active = ctl_val[CTL_RUN];
        end
    end

    always_comb begin
        dev_n = dev_status;
        if (hdev_we)
            dev_n = merge_masked(dev_n, hdev_mask, hdev_val);
        if (ddev_we)
            dev_n = merge_masked(dev_n, ddev_mask, ddev_val);
    end

    assign brk_n = complete ? branch_taken : brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= '0;
            dev_status <= '0;
            brk        <= 1'b0;
        end else begin
            state      <= st_n;
            dev_status <= dev_n;
            brk        <= brk_n;
        end
    end

    a_r3_active_dead_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(state.active && state.dead));

    a_r4_dead_event: assert property (@(posedge clk) disable iff (rst)
        dead_event |=> state.dead && !state.active);

    a_r5_wake_self_clears: assert property (@(posedge clk) disable iff (rst)
        state.wake && !wake_wr |=> !state.wake);

    a_r6_flush_done: assert property (@(posedge clk) disable iff (rst)
        flush_done && !flush_wr |=> !state.flush);

    a_r7_device_wins: assert property (@(posedge clk) disable iff (rst)
        ddev_we |=> (dev_status & $past(ddev_mask)) == ($past(ddev_val) & $past(ddev_mask)));

endmodule

// File: rtl/dmastat_unit.sv
module dmastat_unit
    import dmastat_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_ctl_we,
    input  logic [3:0]              host_ctl_mask,
    input  logic [3:0]              host_ctl_val,
    input  logic                    host_dev_we,
    input  logic [7:0]              host_dev_mask,
    input  logic [7:0]              host_dev_val,
    input  logic                    sel_we,
    input  logic [1:0]              sel_idx,
    input  logic [7:0]              sel_mask,
    input  logic [7:0]              sel_val,
    input  logic                    dev_upd_we,
    input  logic [7:0]              dev_upd_mask,
    input  logic [7:0]              dev_upd_val,
    input  logic                    dead_event,
    input  logic                    flush_done,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_int_flag,
    input  logic [1:0]              cmd_br_flag,
    input  logic [1:0]              cmd_wait_flag,
    input  logic                    cmd_done,
    input  logic [CNT_W-1:0]        cmd_req_count,
    input  logic [CNT_W-1:0]        cmd_xfer_count,
    output logic [15:0]             status,
    output logic                    interrupt_req,
    output logic                    branch_take,
    output logic                    wait_stall,
    output logic                    cmp_valid,
    output logic [STAT_W+CNT_W-1:0] cmp_word
);

    run_state_t                st;
    logic [DEV_W-1:0]          dev;
    logic                      brk;
    logic [NUM_COND-1:0]       req;
    logic [NUM_COND-1:0][1:0]  flags;
    logic [CNT_W-1:0]          residual;
    logic [STAT_W-1:0]         wb_status;

    assign flags[C_INT]  = cmd_int_flag;
    assign flags[C_BR]   = cmd_br_flag;
    assign flags[C_WAIT] = cmd_wait_flag;

    dmastat_cond i_cond (
        .clk        (clk),
        .rst        (rst),
        .sel_we     (sel_we),
        .sel_idx    (sel_idx),
        .sel_mask   (sel_mask),
        .sel_val    (sel_val),
        .dev_status (dev),
        .cmd_valid  (cmd_valid),
        .flags      (flags),
        .req        (req)
    );

    dmastat_ctrl i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ctl_we       (host_ctl_we),
        .ctl_mask     (host_ctl_mask),
        .ctl_val      (host_ctl_val),
        .hdev_we      (host_dev_we),
        .hdev_mask    (host_dev_mask),
        .hdev_val     (host_dev_val),
        .ddev_we      (dev_upd_we),
        .ddev_mask    (dev_upd_mask),
        .ddev_val     (dev_upd_val),
        .dead_event   (dead_event),
        .flush_done   (flush_done),
        .complete     (cmp_valid),
        .branch_taken (branch_take),
        .state        (st),
        .dev_status   (dev),
        .brk          (brk)
    );

    assign interrupt_req = req[C_INT];
    assign branch_take   = req[C_BR];
    assign wait_stall    = req[C_WAIT];

    assign status = {st.run, st.pause, st.flush, st.wake, st.dead, st.active, 1'b0, brk, dev};

    assign cmp_valid = cmd_valid && cmd_done && st.active && !st.pause && !wait_stall;
    assign residual  = cmd_req_count - cmd_xfer_count;
    assign wb_status = {status[15:9], branch_take, status[7:0]};
    assign cmp_word  = {wb_status, residual};

    // R10: a held or inactive channel never completes
    a_r10_no_complete_when_held: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |-> !status[14] && status[10] && !wait_stall);

    // R11: a completion leaves its branch outcome in bit 8
    a_r11_branch_recorded: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> status[8] == $past(branch_take));

    // R2: bit 9 is never set
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        !status[9]);

endmodule

// File: tb/test_dmastat_unit.sv
module test_dmastat_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_ctl_we;
    logic [3:0]  host_ctl_mask, host_ctl_val;
    logic        host_dev_we;
    logic [7:0]  host_dev_mask, host_dev_val;
    logic        sel_we;
    logic [1:0]  sel_idx;
    logic [7:0]  sel_mask, sel_val;
    logic        dev_upd_we;
    logic [7:0]  dev_upd_mask, dev_upd_val;
    logic        dead_event, flush_done;
    logic        cmd_valid;
    logic [1:0]  cmd_int_flag, cmd_br_flag, cmd_wait_flag;
    logic        cmd_done;
    logic [15:0] cmd_req_count, cmd_xfer_count;
    logic [15:0] status;
    logic        interrupt_req, branch_take, wait_stall, cmp_valid;
    logic [31:0] cmp_word;

    always #5 clk = ~clk;

    dmastat_unit i_dmastat_unit (
        .clk(clk), .rst(rst),
        .host_ctl_we(host_ctl_we), .host_ctl_mask(host_ctl_mask), .host_ctl_val(host_ctl_val),
        .host_dev_we(host_dev_we), .host_dev_mask(host_dev_mask), .host_dev_val(host_dev_val),
        .sel_we(sel_we), .sel_idx(sel_idx), .sel_mask(sel_mask), .sel_val(sel_val),
        .dev_upd_we(dev_upd_we), .dev_upd_mask(dev_upd_mask), .dev_upd_val(dev_upd_val),
        .dead_event(dead_event), .flush_done(flush_done),
        .cmd_valid(cmd_valid), .cmd_int_flag(cmd_int_flag), .cmd_br_flag(cmd_br_flag),
        .cmd_wait_flag(cmd_wait_flag), .cmd_done(cmd_done),
        .cmd_req_count(cmd_req_count), .cmd_xfer_count(cmd_xfer_count),
        .status(status), .interrupt_req(interrupt_req), .branch_take(branch_take),
        .wait_stall(wait_stall), .cmp_valid(cmp_valid), .cmp_word(cmp_word)
    );

    int    checks = 0;
    int    errors = 0;
    string tag    = "R1";
    bit    finished = 0;

    // reference model state
    bit       m_run, m_pause, m_flush, m_wake, m_dead, m_active, m_brk;
    bit [7:0] m_dev;
    bit [7:0] m_smask [3];
    bit [7:0] m_sval  [3];

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit flag_out(input int f, input bit c);
        if (f == 0) return 0;
        if (f == 1) return c;
        if (f == 2) return !c;
        return 1;
    endfunction

    function automatic bit [7:0] merge(input bit [7:0] o, input bit [7:0] m, input bit [7:0] v);
        bit [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = m[b] ? v[b] : o[b];
        return r;
    endfunction

    task automatic tick();
        bit [15:0] es;
        bit        ci, cb, cw, ei, eb, ew, ec;
        bit [15:0] res;
        #2;
        es = 16'(m_run) << 15 | 16'(m_pause) << 14 | 16'(m_flush) << 13 | 16'(m_wake) << 12
           | 16'(m_dead) << 11 | 16'(m_active) << 10 | 16'(m_brk) << 8 | 16'(m_dev);
        ci = (m_dev & m_smask[0]) == m_sval[0];
        cb = (m_dev & m_smask[1]) == m_sval[1];
        cw = (m_dev & m_smask[2]) == m_sval[2];
        ei = cmd_valid && flag_out(int'(cmd_int_flag), ci);
        eb = cmd_valid && flag_out(int'(cmd_br_flag), cb);
        ew = cmd_valid && flag_out(int'(cmd_wait_flag), cw);
        ec = cmd_valid && cmd_done && m_active && !m_pause && !ew;
        res = cmd_req_count - cmd_xfer_count;
        check("status", 32'(status), 32'(es));
        check("interrupt_req", 32'(interrupt_req), 32'(ei));
        check("branch_take", 32'(branch_take), 32'(eb));
        check("wait_stall", 32'(wait_stall), 32'(ew));
        check("cmp_valid", 32'(cmp_valid), 32'(ec));
        if (ec) begin
            es[8] = eb;
            check("cmp_word", cmp_word, {es, res});
        end
        @(posedge clk);
        if (rst) begin
            {m_run, m_pause, m_flush, m_wake, m_dead, m_active, m_brk} = '0;
            m_dev = 0;
            for (int k = 0; k < 3; k++) begin m_smask[k] = 0; m_sval[k] = 0; end
        end else begin
            if (host_ctl_we && host_ctl_mask[3]) m_run = host_ctl_val[3];
            if (host_ctl_we && host_ctl_mask[2]) m_pause = host_ctl_val[2];
            if (host_ctl_we && host_ctl_mask[1]) m_flush = host_ctl_val[1];
            else if (flush_done) m_flush = 0;
            m_wake = host_ctl_we && host_ctl_mask[0] && host_ctl_val[0];
            if (dead_event) begin
                m_dead = 1; m_active = 0;
            end else if (host_ctl_we && host_ctl_mask[3]) begin
                m_dead = 0; m_active = host_ctl_val[3];
            end
            if (host_dev_we) m_dev = merge(m_dev, host_dev_mask, host_dev_val);
            if (dev_upd_we) m_dev = merge(m_dev, dev_upd_mask, dev_upd_val);
            if (sel_we && sel_idx != 2'd3) begin
                m_smask[sel_idx] = sel_mask;
                m_sval[sel_idx]  = sel_val;
            end
            if (ec) m_brk = eb;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        host_ctl_we = 0; host_dev_we = 0; sel_we = 0; dev_upd_we = 0;
        dead_event = 0; flush_done = 0;
    endtask

    task automatic ctl(input logic [3:0] m, input logic [3:0] v);
        quiet(); host_ctl_we = 1; host_ctl_mask = m; host_ctl_val = v; tick(); quiet();
    endtask

    task automatic selw(input logic [1:0] i, input logic [7:0] m, input logic [7:0] v);
        quiet(); sel_we = 1; sel_idx = i; sel_mask = m; sel_val = v; tick(); quiet();
    endtask

    task automatic hdev(input logic [7:0] m, input logic [7:0] v);
        quiet(); host_dev_we = 1; host_dev_mask = m; host_dev_val = v; tick(); quiet();
    endtask

    task automatic cmd(input int fi, input int fb, input int fw, input bit v, input bit d);
        cmd_valid = v; cmd_done = d;
        cmd_int_flag = 2'(fi); cmd_br_flag = 2'(fb); cmd_wait_flag = 2'(fw);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; quiet();
        host_ctl_mask = 0; host_ctl_val = 0; host_dev_mask = 0; host_dev_val = 0;
        sel_idx = 0; sel_mask = 0; sel_val = 0; dev_upd_mask = 0; dev_upd_val = 0;
        cmd(0, 0, 0, 0, 0); cmd_req_count = 0; cmd_xfer_count = 0;
        @(negedge clk); tick(); tick();
        rst = 0;

        // R1: reset state; zero selectors make every condition true
        tag = "R1";
        cmd(1, 1, 2, 1, 0); tick();
        cmd(0, 0, 0, 0, 0); tick();

        // R2: pause and flush under mask, unselected bits held
        tag = "R2";
        ctl(4'b0110, 4'b0110); tick();
        ctl(4'b0100, 4'b0000); tick();

        // R3: run sets active, clearing run clears active
        tag = "R3";
        ctl(4'b1000, 4'b1000); tick();
        ctl(4'b1000, 4'b0000); tick();

        // R4: dead event alone and against a run write
        tag = "R4";
        ctl(4'b1000, 4'b1000);
        quiet(); dead_event = 1; tick(); quiet(); tick();
        ctl(4'b1000, 4'b1000); tick();
        quiet(); dead_event = 1; host_ctl_we = 1; host_ctl_mask = 4'b1000; host_ctl_val = 4'b1000;
        tick(); quiet(); tick();

        // R5: wake pulse clears itself, back-to-back keeps it up
        tag = "R5";
        ctl(4'b0001, 4'b0001); tick(); tick();
        ctl(4'b0001, 4'b0001); ctl(4'b0001, 4'b0001); tick();

        // R6: flush_done clears; same-cycle host write wins
        tag = "R6";
        ctl(4'b0010, 4'b0010);
        quiet(); flush_done = 1; tick(); quiet();
        ctl(4'b0010, 4'b0010);
        quiet(); flush_done = 1; host_ctl_we = 1; host_ctl_mask = 4'b0010; host_ctl_val = 4'b0010;
        tick(); quiet(); tick();
        quiet(); flush_done = 1; tick(); quiet();

        // R7: host and device masked updates, overlap and the 0x03/0 clear
        tag = "R7";
        hdev(8'hFF, 8'h5F); tick();
        quiet(); dev_upd_we = 1; dev_upd_mask = 8'h03; dev_upd_val = 8'h00; tick(); quiet();
        quiet(); host_dev_we = 1; host_dev_mask = 8'hF0; host_dev_val = 8'hA0;
        dev_upd_we = 1; dev_upd_mask = 8'h3C; dev_upd_val = 8'h0C; tick(); quiet(); tick();

        // R8: selector loads per index, index 3 ignored
        tag = "R8";
        cmd(1, 1, 1, 1, 0);
        selw(2'd0, 8'h0F, 8'h0C); tick();
        selw(2'd1, 8'hF0, 8'h50); tick();
        selw(2'd2, 8'h01, 8'h01); tick();
        selw(2'd3, 8'hFF, 8'h00); tick();
        cmd(2, 2, 2, 1, 0); tick();

        // R9: every flag encoding against a true and a false condition, all three slots
        tag = "R9";
        for (int s = 0; s < 3; s++) selw(2'(s), 8'hF0, 8'hA0);
        for (int t = 0; t < 2; t++) begin
            hdev(8'hFF, t == 0 ? 8'hA5 : 8'h55);
            for (int f = 0; f < 4; f++) begin
                cmd(f, f, f, 1, 0); tick();
                cmd(f, f, f, 0, 0); tick();
            end
        end

        // R10: completion gating by active, pause and wait
        tag = "R10";
        hdev(8'hFF, 8'hA5);
        cmd(0, 0, 0, 1, 1); tick();
        ctl(4'b1000, 4'b1000);
        cmd(0, 0, 0, 1, 1); tick();
        ctl(4'b0100, 4'b0100); tick();
        ctl(4'b0100, 4'b0000);
        cmd(0, 0, 1, 1, 1); tick();
        cmd(0, 0, 2, 1, 1); tick();
        cmd(0, 0, 0, 1, 0); tick();

        // R11: writeback word with branch outcome and residual, including wrap
        tag = "R11";
        cmd_req_count = 16'd100; cmd_xfer_count = 16'd37;
        cmd(1, 3, 0, 1, 1); tick();
        cmd(0, 0, 0, 0, 0); tick();
        cmd_req_count = 16'd5; cmd_xfer_count = 16'd10;
        cmd(0, 0, 0, 1, 1); tick();
        cmd(0, 0, 0, 0, 0); tick();
        cmd_req_count = 16'hFFFF; cmd_xfer_count = 16'h0000;
        cmd(0, 1, 0, 1, 1); tick();
        cmd(0, 0, 0, 0, 0); tick();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule